// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss in hardware for a 32-bit virtual address space with 4 KB pages. Given a virtual address and the physical base of the top-level table, it splits the page number into an upper index that selects a directory entry and a lower index that selects a page table entry. It fetches the directory entry first and then the final entry through a single read port with a request/grant phase and a separate response strobe. The result is either the final entry, ready to be written into a TLB, or a fault that names the level at which the walk stopped.

Only one walk is in flight at a time. The block raises its request-ready output only when it is idle. It keeps the result on its outputs until the consumer takes it. A directory entry whose valid bit is clear ends the walk at once with a level-0 fault. An invalid final entry gives a level-1 fault.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1 and res_valid_o and mem_req_o are 0.
- R2: req_ready_o is 1 only when no walk is running and no result is pending. A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. req_vaddr_i and root_base_i are captured on that edge, and later changes to either have no effect on the walk.
- R3: The first read goes to root + vaddr[31:22]*4. With zero-wait memory (grant in the request cycle, response on the next cycle), a successful walk shows res_valid_o 5 cycles after the accepting edge.
- R4: Bit 0 of an entry is its valid bit. If the directory entry has bit 0 clear, the walk ends with res_fault_o=1 and res_fault_lvl_o=0. No second read is issued, and a zero-wait walk shows res_valid_o 3 cycles after acceptance.
- R5: The second read goes to {dir_entry[31:12], 12'h000} + vaddr[21:12]*4.
- R6: If the final entry has bit 0 set, res_fault_o=0, res_pte_o is that entry, res_ppn_o is its bits 31:12 and res_flags_o is its bits 11:1. If bit 0 is clear, res_fault_o=1, res_fault_lvl_o=1, and res_pte_o shows the failing entry.
- R7: While mem_gnt_i is low, mem_req_o stays high and mem_addr_o stays stable.
- R8: The result outputs hold their values while res_valid_o=1 and res_ready_i=0. After an edge with res_ready_i=1, the block is idle again (req_ready_o=1, res_valid_o=0).
- R9: mem_rvalid_i is ignored unless a read has been granted and its response is awaited.
- R10: res_vpn_o equals bits 31:12 of the captured virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| root_base_i | input | 32 | Physical base of the directory |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_gnt_i | input | 1 | Read request granted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result taken |
| res_fault_o | output | 1 | Walk ended in a fault |
| res_fault_lvl_o | output | 1 | Fault level: 0 directory, 1 final entry |
| res_vpn_o | output | 20 | Virtual page number of the walk |
| res_pte_o | output | 32 | Last entry read |
| res_ppn_o | output | 20 | Physical page number of the entry |
| res_flags_o | output | 11 | Flag bits of the entry |

## Verification
The bench memory grants in the request cycle unless a stall is injected, and it answers one cycle after the grant. An accepted walk therefore reaches its result after five edges when it succeeds and after three when the directory entry faults. Each injected grant stall adds exactly one cycle. Every walk task counts the falling edges from acceptance to res_valid_o and compares that count with these figures, so a late or early result is caught. All outputs are sampled on the falling edge, half a period after the edge that updates them. A release of the result is checked on the falling edge that follows the edge that takes it.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DIR,
    ST_WT_DIR,
    ST_RD_PTE,
    ST_WT_PTE,
    ST_DONE,
    ST_FAULT
  } walk_st_e;

  localparam int unsigned ENT_VALID_BIT = 0;
endpackage

// File: rtl/pt_walk_split.sv
module pt_walk_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned DIR_W  = 10,
  localparam int unsigned VPN_W = ADDR_W - OFF_W,
  localparam int unsigned TBL_W = VPN_W - DIR_W
) (
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic [DIR_W-1:0]  dir_idx_o,
  output logic [TBL_W-1:0]  tbl_idx_o,
  output logic [VPN_W-1:0]  vpn_o
);
  assign vpn_o     = vaddr_i[ADDR_W-1:OFF_W];
  assign dir_idx_o = vpn_o[VPN_W-1:TBL_W];
  assign tbl_idx_o = vpn_o[TBL_W-1:0];
endmodule

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned DIR_W   = 10,
  parameter int unsigned ENT_LOG = 2,
  localparam int unsigned TBL_W  = ADDR_W - OFF_W - DIR_W
) (
  input  logic              lvl_pte_i,
  input  logic [ADDR_W-1:0] root_i,
  input  logic [ADDR_W-1:0] ent_i,
  input  logic [DIR_W-1:0]  dir_idx_i,
  input  logic [TBL_W-1:0]  tbl_idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base, off;

  always_comb begin
    if (lvl_pte_i) begin
      base = {ent_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      off  = ADDR_W'(tbl_idx_i) << ENT_LOG;
    end else begin
      base = root_i;
      off  = ADDR_W'(dir_idx_i) << ENT_LOG;
    end
    addr_o = base + off;
  end
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_gnt_i,
  input  logic mem_rvalid_i,
  input  logic ent_valid_i,
  input  logic res_ready_i,
  output logic req_ready_o,
  output logic mem_req_o,
  output logic lvl_pte_o,
  output logic ent_load_o,
  output logic res_valid_o,
  output logic res_fault_o,
  output logic fault_lvl_o
);
  walk_st_e st_q, st_d;
  logic     lvl_q;

  always_comb begin
    st_d       = st_q;
    ent_load_o = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (req_valid_i) st_d = ST_RD_DIR;
      ST_RD_DIR: if (mem_gnt_i) st_d = ST_WT_DIR;
      ST_WT_DIR: if (mem_rvalid_i) begin
        ent_load_o = 1'b1;
        st_d       = ent_valid_i ? ST_RD_PTE : ST_FAULT;
      end
      ST_RD_PTE: if (mem_gnt_i) st_d = ST_WT_PTE;
      ST_WT_PTE: if (mem_rvalid_i) begin
        ent_load_o = 1'b1;
        st_d       = ent_valid_i ? ST_DONE : ST_FAULT;
      end
      ST_DONE, ST_FAULT: if (res_ready_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      lvl_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (ent_load_o) lvl_q <= (st_q == ST_WT_PTE);
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_RD_DIR) || (st_q == ST_RD_PTE);
  assign lvl_pte_o   = (st_q == ST_RD_PTE) || (st_q == ST_WT_PTE);
  assign res_valid_o = (st_q == ST_DONE) || (st_q == ST_FAULT);
  assign res_fault_o = (st_q == ST_FAULT);
  assign fault_lvl_o = lvl_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned DIR_W   = 10,
  parameter int unsigned ENT_LOG = 2,
  localparam int unsigned VPN_W  = ADDR_W - OFF_W,
  localparam int unsigned TBL_W  = VPN_W - DIR_W,
  localparam int unsigned FLG_W  = OFF_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [ADDR_W-1:0] root_base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              res_fault_o,
  output logic              res_fault_lvl_o,
  output logic [VPN_W-1:0]  res_vpn_o,
  output logic [ADDR_W-1:0] res_pte_o,
  output logic [VPN_W-1:0]  res_ppn_o,
  output logic [FLG_W-1:0]  res_flags_o
);
  logic [ADDR_W-1:0] vaddr_q, root_q, ent_q;
  logic [DIR_W-1:0]  dir_idx;
  logic [TBL_W-1:0]  tbl_idx;
  logic              accept, lvl_pte, ent_load;

  assign accept = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      root_q  <= '0;
      ent_q   <= '0;
    end else begin
      if (accept) begin
        vaddr_q <= req_vaddr_i;
        root_q  <= root_base_i;
      end
      if (ent_load) ent_q <= mem_rdata_i;
    end
  end

  pt_walk_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DIR_W(DIR_W)) u_split (
    .vaddr_i   (vaddr_q),
    .dir_idx_o (dir_idx),
    .tbl_idx_o (tbl_idx),
    .vpn_o     (res_vpn_o)
  );

  pt_walk_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .ENT_LOG(ENT_LOG)) u_addr (
    .lvl_pte_i (lvl_pte),
    .root_i    (root_q),
    .ent_i     (ent_q),
    .dir_idx_i (dir_idx),
    .tbl_idx_i (tbl_idx),
    .addr_o    (mem_addr_o)
  );

  pt_walk_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .ent_valid_i  (mem_rdata_i[ENT_VALID_BIT]),
    .res_ready_i  (res_ready_i),
    .req_ready_o  (req_ready_o),
    .mem_req_o    (mem_req_o),
    .lvl_pte_o    (lvl_pte),
    .ent_load_o   (ent_load),
    .res_valid_o  (res_valid_o),
    .res_fault_o  (res_fault_o),
    .fault_lvl_o  (res_fault_lvl_o)
  );

  assign res_pte_o   = ent_q;
  assign res_ppn_o   = ent_q[ADDR_W-1:OFF_W];
  assign res_flags_o = ent_q[OFF_W-1:1];
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_gnt_i,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic              res_fault_o,
  input logic              res_fault_lvl_o,
  input logic [ADDR_W-1:0] res_pte_o
);
  a_r2_busy_when_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !req_ready_o);

  a_r2_no_read_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o);

  a_r7_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_pte_o)
      && $stable(res_fault_o) && $stable(res_fault_lvl_o));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_ready_i |=> req_ready_o && !res_valid_o);

  a_r6_ok_entry_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_fault_o |-> res_pte_o[0]);

  a_r4_fault_entry_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_fault_o |-> !res_pte_o[0]);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .mem_req_o       (mem_req_o),
  .mem_addr_o      (mem_addr_o),
  .mem_gnt_i       (mem_gnt_i),
  .res_valid_o     (res_valid_o),
  .res_ready_i     (res_ready_i),
  .res_fault_o     (res_fault_o),
  .res_fault_lvl_o (res_fault_lvl_o),
  .res_pte_o       (res_pte_o)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [31:0] root_base_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_gnt_i;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        res_valid_o;
  logic        res_ready_i = 1'b0;
  logic        res_fault_o;
  logic        res_fault_lvl_o;
  logic [19:0] res_vpn_o;
  logic [31:0] res_pte_o;
  logic [19:0] res_ppn_o;
  logic [10:0] res_flags_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  logic        gnt_en = 1'b1;
  logic        stray = 1'b0;
  logic        rvalid_q = 1'b0;
  logic [31:0] rdata_q = '0;
  logic [31:0] mem_q [logic [31:0]];
  logic [31:0] rd_log [0:15];
  int          n_rd = 0;

  always #4 clk_i = ~clk_i;

  pt_walker u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_vaddr_i, .root_base_i,
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .res_valid_o, .res_ready_i, .res_fault_o, .res_fault_lvl_o,
    .res_vpn_o, .res_pte_o, .res_ppn_o, .res_flags_o
  );

  assign mem_gnt_i    = mem_req_o & gnt_en;
  assign mem_rvalid_i = rvalid_q | stray;
  assign mem_rdata_i  = rdata_q;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_q.exists(a) ? mem_q[a] : 32'h0;
  endfunction

  always @(posedge clk_i) begin
    cyc      <= cyc + 1;
    rvalid_q <= mem_req_o & mem_gnt_i;
    rdata_q  <= rd(mem_addr_o);
    if (mem_req_o & mem_gnt_i) begin
      rd_log[n_rd[3:0]] <= mem_addr_o;
      n_rd <= n_rd + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_addr(input logic [31:0] root, input logic [31:0] va);
    return root + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] pte_addr(input logic [31:0] de, input logic [31:0] va);
    return {de[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
  endfunction

  // drives one request; returns falling edges from acceptance to result and read count
  task automatic walk(input logic [31:0] va, input logic [31:0] root,
                      output int lat, output int reads, output int first);
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    root_base_i = root;
    first = n_rd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    root_base_i = 32'hDEAD_0000;
    lat = 1;
    while (!res_valid_o && lat < 60) begin
      @(negedge clk_i);
      lat++;
    end
    reads = n_rd - first;
  endtask

  task automatic take_result;
    res_ready_i = 1'b1;
    @(negedge clk_i);
    res_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(req_ready_o), 32'd1);
    chk("R1 res_valid", 32'(res_valid_o), 32'd0);
    chk("R1 mem_req", 32'(mem_req_o), 32'd0);
  endtask

  task automatic t_ok(input logic [31:0] va, input logic [31:0] root,
                      input logic [31:0] de, input logic [31:0] pte);
    int lat, reads, f;
    mem_q[dir_addr(root, va)] = de;
    mem_q[pte_addr(de, va)]   = pte;
    walk(va, root, lat, reads, f);
    chk("R3 latency", 32'(lat), 32'd5);
    chk("R3 dir addr", rd_log[f[3:0]], dir_addr(root, va));
    chk("R5 pte addr", rd_log[4'(f + 1)], pte_addr(de, va));
    chk("R6 reads", 32'(reads), 32'd2);
    chk("R6 fault", 32'(res_fault_o), 32'd0);
    chk("R6 pte", res_pte_o, pte);
    chk("R6 ppn", 32'(res_ppn_o), 32'(pte[31:12]));
    chk("R6 flags", 32'(res_flags_o), 32'(pte[11:1]));
    chk("R10 vpn", 32'(res_vpn_o), 32'(va[31:12]));
    take_result();
    chk("R8 idle again", 32'({req_ready_o, res_valid_o}), 32'b10);
  endtask

  task automatic t_dir_fault;
    int lat, reads, f;
    logic [31:0] va = 32'h8040_1000, root = 32'h0002_0000;
    mem_q[dir_addr(root, va)] = 32'h0055_5000;
    walk(va, root, lat, reads, f);
    chk("R4 latency", 32'(lat), 32'd3);
    chk("R4 reads", 32'(reads), 32'd1);
    chk("R4 fault", 32'({res_fault_o, res_fault_lvl_o}), 32'b10);
    chk("R4 entry", res_pte_o, 32'h0055_5000);
    take_result();
  endtask

  task automatic t_pte_fault;
    int lat, reads, f;
    logic [31:0] va = 32'h0040_2000, root = 32'h0003_0000;
    mem_q[dir_addr(root, va)] = 32'h0007_7001;
    mem_q[pte_addr(32'h0007_7001, va)] = 32'h1234_50FE;
    walk(va, root, lat, reads, f);
    chk("R6 pte fault latency", 32'(lat), 32'd5);
    chk("R6 pte fault", 32'({res_fault_o, res_fault_lvl_o}), 32'b11);
    chk("R6 fault entry", res_pte_o, 32'h1234_50FE);
    take_result();
  endtask

  task automatic t_stall;
    int lat, f;
    logic [31:0] va = 32'h0C80_3000, root = 32'h0004_0000;
    logic [31:0] a0;
    mem_q[dir_addr(root, va)] = 32'h0009_9001;
    mem_q[pte_addr(32'h0009_9001, va)] = 32'h000A_A003;
    gnt_en = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = va; root_base_i = root; f = n_rd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    a0 = mem_addr_o;
    stray = 1'b1;
    @(negedge clk_i);
    stray = 1'b0;
    @(negedge clk_i);
    chk("R7 req held", 32'(mem_req_o), 32'd1);
    chk("R7 addr held", mem_addr_o, a0);
    chk("R9 no stray capture", 32'(res_valid_o), 32'd0);
    gnt_en = 1'b1;
    lat = 0;
    while (!res_valid_o && lat < 60) begin
      @(negedge clk_i);
      lat++;
    end
    chk("R7 stall latency", 32'(lat), 32'd4);
    chk("R9 result after stray", res_pte_o, 32'h000A_A003);
    chk("R7 dir addr", rd_log[f[3:0]], dir_addr(root, va));
    take_result();
  endtask

  task automatic t_backpressure;
    int lat, reads, f, base;
    logic [31:0] va = 32'h0000_5000, root = 32'h0005_0000;
    mem_q[dir_addr(root, va)] = 32'h000B_B001;
    mem_q[pte_addr(32'h000B_B001, va)] = 32'h000C_C00F;
    walk(va, root, lat, reads, f);
    base = n_rd;
    req_valid_i = 1'b1; req_vaddr_i = 32'hFFFF_F000;
    repeat (4) @(negedge clk_i);
    chk("R2 ready low while pending", 32'(req_ready_o), 32'd0);
    chk("R2 no new read", 32'(n_rd - base), 32'd0);
    chk("R8 pte held", res_pte_o, 32'h000C_C00F);
    chk("R8 valid held", 32'(res_valid_o), 32'd1);
    req_valid_i = 1'b0;
    take_result();
    chk("R8 released", 32'({req_ready_o, res_valid_o}), 32'b10);
  endtask

  task automatic t_idle_stray;
    stray = 1'b1;
    @(negedge clk_i);
    stray = 1'b0;
    @(negedge clk_i);
    chk("R9 idle stray", 32'({req_ready_o, res_valid_o, mem_req_o}), 32'b100);
  endtask

  initial begin
    int lim = 100000;
    while (cyc < lim) @(negedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp<%0d", cyc, lim);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ok(32'h1234_5678, 32'h0001_0000, 32'h0006_6001, 32'h0ABC_D0A7);
    t_ok(32'hFFFF_F000, 32'h0001_0000, 32'hFFFF_E001, 32'hFEDC_BFFF);
    t_ok(32'h0000_0000, 32'h0020_0000, 32'h0030_0001, 32'h0000_1001);
    t_dir_fault();
    t_pte_fault();
    t_stall();
    t_backpressure();
    t_idle_stray();
    t_ok(32'h0040_0ABC, 32'h0007_0000, 32'h0011_1003, 32'h0022_2801);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule